// File: doc/BRIEF.md
# DMA Controller Control-Port Registers

This block is the control side of a four-channel DMA controller. A byte-wide register port with a 3-bit function offset decodes eight write functions and answers two reads. It holds the command byte, one mask bit per channel, a status byte and a 6-bit mode field per channel. It drives all of these to the channel bank and to the transfer engine. It also pulses a strobe whenever the byte-sequencing flip-flop in the channel bank must return to its first byte.

The status byte has two halves. Request flags sit in the upper nibble, one per channel at bit position channel+4. Hardware requests and software request writes update these flags. Terminal-count flags sit in the lower nibble at bit position channel. The transfer engine raises them, and a status read clears them. A command write is filtered: only the controller-disable bit is accepted, and any other feature request leaves the register untouched.

Top module: `dma_ctrl_regs`

## Requirements
- R1: After power-on reset, mask_o is 4'hF, and status_o, cmd_o and every mode field are zero.
- R2: A write at offset 0 loads cmd_o only when the data is 8'h00 or 8'h04. Any other value leaves cmd_o unchanged.
- R3: A write at offset 1 selects channel c = data[1:0]. It sets status bit c+4 to data[2] and clears status bit c.
- R4: A write at offset 2 sets mask bit data[1:0] to data[2] and leaves the other mask bits unchanged.
- R5: A write at offset 6 clears all mask bits. A write at offset 7 loads the mask from data[3:0].
- R6: A write at offset 3 stores data[7:2] in the mode field of channel data[1:0]. That field is mode_o[6c+5:6c], and the other channels' fields are unchanged.
- R7: ff_clr_o is high in exactly those cycles that carry a write at offset 4 or 5.
- R8: A write at offset 5 sets every mask bit and clears status and cmd_o. It leaves the mode fields unchanged.
- R9: With rd_en high, rd_data shows status_o at offset 0 and the mask (zero-extended) at offset 1. It shows 0 at offsets 2 to 7, and 0 whenever rd_en is low. A read at offset 0 clears the low status nibble after that cycle.
- R10: A pulse on req_set[c] sets status bit c+4, and a pulse on req_clr[c] clears it. If both pulse together, set wins. A software request write to the same channel in the same cycle overrides both.
- R11: A pulse on tc_set[c] sets status bit c. It survives a same-cycle status read. A same-cycle software request write to channel c clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe for the register port |
| addr | input | 3 | Function offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational) |
| req_set | input | NUM_CH | Hardware request assert pulses |
| req_clr | input | NUM_CH | Hardware request release pulses |
| tc_set | input | NUM_CH | Terminal-count pulses from the transfer engine |
| mask_o | output | NUM_CH | Channel mask bits |
| status_o | output | 2*NUM_CH | Request flags (high half) and terminal-count flags (low half) |
| cmd_o | output | 8 | Command byte |
| mode_o | output | 6*NUM_CH | Packed per-channel mode fields |
| ff_clr_o | output | 1 | Flip-flop clear strobe |

## Verification
The bench uses the default CH_W = 2, which gives four channels and an 8-bit status byte filled exactly by the two nibbles. With these defaults, every channel code in data[1:0] can be exercised. So can every collision the status byte can see: a hardware set against a software clear on one channel, a terminal count against a status read, and a master reset against pending flags. A behavioural model is compared against every output on every clock. Directed checks pin down the exact values for each of these cases.

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs #(
  parameter int CH_W = 2,
  localparam int NUM_CH = 1 << CH_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [2:0]            addr,
  input  logic [7:0]            wr_data,
  output logic [7:0]            rd_data,
  input  logic [NUM_CH-1:0]     req_set,
  input  logic [NUM_CH-1:0]     req_clr,
  input  logic [NUM_CH-1:0]     tc_set,
  output logic [NUM_CH-1:0]     mask_o,
  output logic [2*NUM_CH-1:0]   status_o,
  output logic [7:0]            cmd_o,
  output logic [6*NUM_CH-1:0]   mode_o,
  output logic                  ff_clr_o
);

  localparam logic [2:0] OF_CMD   = 3'd0;
  localparam logic [2:0] OF_SWREQ = 3'd1;
  localparam logic [2:0] OF_MASK1 = 3'd2;
  localparam logic [2:0] OF_MODE  = 3'd3;
  localparam logic [2:0] OF_FFCLR = 3'd4;
  localparam logic [2:0] OF_MRST  = 3'd5;
  localparam logic [2:0] OF_UNMSK = 3'd6;
  localparam logic [2:0] OF_MSKALL= 3'd7;
  localparam logic [7:0] CMD_KEEP = 8'h04;

  logic [NUM_CH-1:0] mask_q, mask_nxt;
  logic [NUM_CH-1:0] req_q, req_nxt;
  logic [NUM_CH-1:0] tc_q, tc_nxt;
  logic [7:0]        cmd_q;
  logic [5:0]        mode_q [NUM_CH];

  logic [CH_W-1:0] sel;
  logic            flag, master_rst, status_rd, cmd_ok;

  assign sel        = wr_data[CH_W-1:0];
  assign flag       = wr_data[CH_W];
  assign master_rst = wr_en && addr == OF_MRST;
  assign status_rd  = rd_en && addr == OF_CMD;
  assign cmd_ok     = (wr_data & ~CMD_KEEP) == 8'h00;
  assign ff_clr_o   = wr_en && (addr == OF_FFCLR || addr == OF_MRST);

  always_comb begin
    req_nxt  = (req_q & ~req_clr) | req_set;
    tc_nxt   = (tc_q & ~{NUM_CH{status_rd}}) | tc_set;
    mask_nxt = mask_q;
    if (wr_en) begin
      case (addr)
        OF_SWREQ: begin
          req_nxt[sel] = flag;
          tc_nxt[sel]  = 1'b0;
        end
        OF_MASK1:  mask_nxt[sel] = flag;
        OF_UNMSK:  mask_nxt = '0;
        OF_MSKALL: mask_nxt = wr_data[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      cmd_q  <= '0;
      for (int i = 0; i < NUM_CH; i++) mode_q[i] <= '0;
    end else if (master_rst) begin
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      cmd_q  <= '0;
    end else begin
      mask_q <= mask_nxt;
      req_q  <= req_nxt;
      tc_q   <= tc_nxt;
      if (wr_en && addr == OF_CMD && cmd_ok) cmd_q <= wr_data;
      if (wr_en && addr == OF_MODE) mode_q[sel] <= wr_data[7:2];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_mode
    assign mode_o[6*g +: 6] = mode_q[g];
  end

  assign mask_o   = mask_q;
  assign status_o = {req_q, tc_q};
  assign cmd_o    = cmd_q;

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) begin
      case (addr)
        OF_CMD:   rd_data = 8'(status_o);
        OF_SWREQ: rd_data = 8'(mask_q);
        default:  rd_data = 8'h00;
      endcase
    end
  end

  a_r8_master_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OF_MRST) |=> (mask_o == '1 && status_o == '0 && cmd_o == 8'h00));

  a_r2_cmd_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OF_CMD && wr_data != 8'h00 && wr_data != 8'h04) |=> $stable(cmd_o));

  a_r9_tc_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OF_CMD && tc_set == '0) |=> (status_o[NUM_CH-1:0] == '0));

  a_r4_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OF_MASK1) |=> (mask_o[$past(wr_data[CH_W-1:0])] == $past(wr_data[CH_W])));

  a_r6_mode_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OF_MODE) |=> (mode_o[6*$past(wr_data[CH_W-1:0]) +: 6] == $past(wr_data[7:2])));

  a_r3_sw_request: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OF_SWREQ) |=>
      (status_o[NUM_CH + $past(wr_data[CH_W-1:0])] == $past(wr_data[CH_W]) &&
       status_o[$past(wr_data[CH_W-1:0])] == 1'b0));

  a_r5_unmask_all: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OF_UNMSK) |=> (mask_o == '0));

endmodule

// File: tb/tb_dma_ctrl_regs.sv
`timescale 1ns/1ps
module tb_dma_ctrl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] req_set = '0, req_clr = '0, tc_set = '0;
  logic [7:0] rd_data;
  logic [3:0] mask_o;
  logic [7:0] status_o;
  logic [7:0] cmd_o;
  logic [23:0] mode_o;
  logic ff_clr_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .req_set(req_set), .req_clr(req_clr),
    .tc_set(tc_set), .mask_o(mask_o), .status_o(status_o), .cmd_o(cmd_o),
    .mode_o(mode_o), .ff_clr_o(ff_clr_o)
  );

  // behavioural reference model
  logic [3:0] e_mask;
  logic [7:0] e_stat, e_cmd, s;
  logic [5:0] e_mode [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_mask = 4'hF; e_stat = 0; e_cmd = 0;
      for (int i = 0; i < 4; i++) e_mode[i] = 0;
    end else begin
      s = e_stat;
      for (int c = 0; c < 4; c++) begin
        if (req_set[c]) s[c+4] = 1'b1;
        else if (req_clr[c]) s[c+4] = 1'b0;
      end
      if (rd_en && addr == 3'd0) s[3:0] = 4'h0;
      s[3:0] = s[3:0] | tc_set;
      if (wr_en) begin
        case (addr)
          3'd0: if (wr_data == 8'h00 || wr_data == 8'h04) e_cmd = wr_data;
          3'd1: begin s[wr_data[1:0] + 4] = wr_data[2]; s[wr_data[1:0]] = 1'b0; end
          3'd2: e_mask[wr_data[1:0]] = wr_data[2];
          3'd3: e_mode[wr_data[1:0]] = wr_data[7:2];
          3'd5: begin s = 0; e_mask = 4'hF; e_cmd = 0; end
          3'd6: e_mask = 0;
          3'd7: e_mask = wr_data[3:0];
          default: ;
        endcase
      end
      e_stat = s;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] erd;
      erd = 0;
      if (rd_en && addr == 3'd0) erd = e_stat;
      else if (rd_en && addr == 3'd1) erd = {4'h0, e_mask};
      check("R4/R5/R8 mask", mask_o, e_mask);
      check("R3/R10/R11 status", status_o, e_stat);
      check("R2 cmd", cmd_o, e_cmd);
      check("R6 mode", mode_o, {e_mode[3], e_mode[2], e_mode[1], e_mode[0]});
      check("R7 ff_clr", ff_clr_o, wr_en && (addr == 3'd4 || addr == 3'd5));
      check("R9 rd_data", rd_data, erd);
    end
  end

  task automatic op(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d,
                    input logic [3:0] rs, input logic [3:0] rc, input logic [3:0] ts);
    @(posedge clk); #1;
    wr_en = w; rd_en = r; addr = a; wr_data = d; req_set = rs; req_clr = rc; tc_set = ts;
  endtask
  task automatic idle(); op(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d); op(1, 0, a, d, 0, 0, 0); endtask
  task automatic settle(); idle(); @(negedge clk); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset mask", mask_o, 4'hF);
    check("R1 reset status", status_o, 0);
    check("R1 reset cmd", cmd_o, 0);
    check("R1 reset mode", mode_o, 0);

    wr(0, 8'h04); settle(); check("R2 accept 04", cmd_o, 8'h04);
    wr(0, 8'h14); settle(); check("R2 reject 14", cmd_o, 8'h04);
    wr(0, 8'h05); settle(); check("R2 reject 05", cmd_o, 8'h04);
    wr(0, 8'h00); settle(); check("R2 accept 00", cmd_o, 8'h00);

    wr(1, 8'h06); settle(); check("R3 sw set ch2", status_o, 8'h40);
    op(0, 0, 0, 0, 0, 0, 4'h4); settle(); check("R11 tc ch2", status_o, 8'h44);
    wr(1, 8'h02); settle(); check("R3 sw clear ch2", status_o, 8'h00);
    op(1, 0, 1, 8'h05, 0, 0, 4'h2); settle(); check("R11 sw wins over tc ch1", status_o, 8'h20);
    wr(1, 8'h01); settle();

    wr(2, 8'h01); settle(); check("R4 unmask ch1", mask_o, 4'hD);
    wr(2, 8'h05); settle(); check("R4 mask ch1", mask_o, 4'hF);
    wr(6, 8'hFF); settle(); check("R5 clear all", mask_o, 4'h0);
    wr(7, 8'hA5); settle(); check("R5 write all", mask_o, 4'h5);

    wr(3, 8'hD7); settle(); check("R6 mode ch3", mode_o[23:18], 6'h35);
    check("R6 others", mode_o[17:0], 0);
    wr(3, 8'h28); settle(); check("R6 mode ch0", mode_o[5:0], 6'h0A);

    wr(4, 8'h00); @(negedge clk); check("R7 strobe on 4", ff_clr_o, 1);
    settle(); check("R7 strobe gone", ff_clr_o, 0);

    op(0, 0, 0, 0, 4'h8, 0, 4'h3); settle(); check("R10 hw set ch3", status_o, 8'h83);
    op(0, 1, 0, 0, 0, 0, 0); @(negedge clk); check("R9 status read", rd_data, 8'h83);
    settle(); check("R9 tc cleared", status_o, 8'h80);
    op(0, 1, 1, 0, 0, 0, 0); @(negedge clk); check("R9 mask read", rd_data, 8'h05);
    op(0, 1, 6, 0, 0, 0, 0); @(negedge clk); check("R9 other read", rd_data, 8'h00);
    op(0, 0, 0, 0, 0, 0, 0); @(negedge clk); check("R9 no rd_en", rd_data, 8'h00);

    op(0, 0, 0, 0, 0, 0, 4'h1); settle();
    op(0, 1, 0, 0, 0, 0, 4'h2); @(negedge clk); check("R11 read sees old", rd_data, 8'h81);
    settle(); check("R11 tc survives read", status_o, 8'h82);

    op(1, 0, 1, 8'h00, 4'h1, 0, 0); settle(); check("R10 sw beats hw set", status_o[4], 0);
    op(0, 0, 0, 0, 4'h2, 0, 0); settle(); check("R10 hw set ch1", status_o[5], 1);
    op(0, 0, 0, 0, 0, 4'h2, 0); settle(); check("R10 hw clr ch1", status_o[5], 0);
    op(0, 0, 0, 0, 4'h2, 4'h2, 0); settle(); check("R10 set beats clr", status_o[5], 1);
    op(1, 0, 1, 8'h05, 0, 4'h2, 0); settle(); check("R10 sw beats hw clr", status_o[5], 1);

    wr(0, 8'h04); settle();
    op(1, 0, 5, 8'h00, 0, 0, 4'hF); @(negedge clk); check("R7 strobe on 5", ff_clr_o, 1);
    settle();
    check("R8 mask", mask_o, 4'hF);
    check("R8 status", status_o, 0);
    check("R8 cmd", cmd_o, 0);
    check("R8 mode kept", mode_o[23:18], 6'h35);

    for (int k = 0; k < 40; k++) begin
      op((k % 3) != 0, (k % 4) == 0, 3'(k * 5), 8'(k * 37), 4'(k), 4'(k >> 1), 4'(k * 3));
    end
    settle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule